// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block keeps four 16-bit segment bases (code, stack, data and extra) and forms a 20-bit physical address from a 16-bit offset. The base is shifted left by four bit positions and the offset is added, so any of the 1 MB locations can be reached. Each segment covers a 64 KB window. Within one cycle the address is a purely combinational function of the stored bases and the current request.

The caller states which kind of register supplied the offset. The block uses that to pick the default segment. An instruction-pointer offset always uses the code segment. A stack-pointer or base-pointer offset uses the stack segment. An offset from a general or index register uses the data segment. For every request other than an instruction fetch, a qualified override may name a different segment.

There are three update paths, and each one may reach only certain segment registers:
- a far control transfer, which is the only way to change the code base;
- a pop;
- a load of a far pointer.

When several paths request a write in the same cycle, a fixed priority decides, and only one register changes.

Top module: `seg_addr_unit`

## Requirements
- R1: `phys_addr` equals ((base << 4) + `offset`) modulo 2^20. A carry out of bit 19 is discarded, so the sum wraps to the bottom of memory.
- R2: When `base_kind` = 00 (instruction pointer), the code segment is used whatever `ovr_valid` and `ovr_seg` hold.
- R3: When `base_kind` = 01 (stack or base pointer) and `ovr_valid` = 0, the stack segment is used.
- R4: When `base_kind` = 10 (general register) or 11 (index register) and `ovr_valid` = 0, the data segment is used.
- R5: When `ovr_valid` = 1 and `base_kind` is not 00, the segment named by `ovr_seg` is used. The codes are 00 extra, 01 code, 10 stack and 11 data. When `ovr_valid` = 0, `ovr_seg` has no effect.
- R6: While `rst_n` is low and after it is released, the code base is 0xFFFF and the stack, data and extra bases are 0x0000.
- R7: The code base changes only on a clock edge with `far_we` = 1, and takes the value of `far_cs`.
- R8: A pop with `pop_we` = 1 loads `pop_data` into the segment named by `pop_seg`, using the R5 codes: 00 extra, 10 stack, 11 data. A pop naming code (01) is discarded, changes nothing and does not count as a request.
- R9: A load-far-pointer with `lfp_we` = 1 loads `lfp_ds` into the data base.
- R10: Write priority is far transfer, then valid pop, then load-far-pointer. At most one base is written per edge, and the losing requests are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_kind | input | 2 | Source of the offset: 00 instruction pointer, 01 stack/base pointer, 10 general register, 11 index register |
| offset | input | 16 | Offset within the segment |
| ovr_valid | input | 1 | Qualifies `ovr_seg` |
| ovr_seg | input | 2 | Override segment: 00 extra, 01 code, 10 stack, 11 data |
| far_we | input | 1 | Far transfer writes the code base |
| far_cs | input | 16 | New code base |
| pop_we | input | 1 | Pop writes a segment base |
| pop_seg | input | 2 | Pop target, same codes as `ovr_seg` |
| pop_data | input | 16 | Popped value |
| lfp_we | input | 1 | Load-far-pointer writes the data base |
| lfp_ds | input | 16 | New data base |
| phys_addr | output | 20 | Physical address |

## Verification
The stability properties assume that every write request is held only for a whole cycle and is sampled at the rising edge. The bench therefore changes the request inputs only on falling edges. Address checks are made in cycles with all write enables low, so the bases seen are those of the last edge. The override rule applies only to non-fetch kinds, and the stimulus deliberately pairs fetches with a valid override to test that it is ignored. Stored bases are observed only through the address port, using offset zero or a known offset with the matching kind or override.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

  localparam int NUM_SEGS = 4;

  typedef enum logic [1:0] {
    SEG_EXTRA = 2'b00,
    SEG_CODE  = 2'b01,
    SEG_STACK = 2'b10,
    SEG_DATA  = 2'b11
  } seg_id_e;

  typedef enum logic [1:0] {
    BASE_IP  = 2'b00,
    BASE_STK = 2'b01,
    BASE_GEN = 2'b10,
    BASE_IDX = 2'b11
  } base_kind_e;

  // Default segment chosen from the kind of offset register.
  function automatic seg_id_e default_seg(input base_kind_e kind);
    case (kind)
      BASE_IP:  return SEG_CODE;
      BASE_STK: return SEG_STACK;
      default:  return SEG_DATA;
    endcase
  endfunction

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter logic [SEG_W-1:0] CS_RST = {SEG_W{1'b1}}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             far_we,
  input  logic [SEG_W-1:0] far_cs,
  input  logic             pop_we,
  input  logic [1:0]       pop_seg,
  input  logic [SEG_W-1:0] pop_data,
  input  logic             lfp_we,
  input  logic [SEG_W-1:0] lfp_ds,
  output logic [SEG_W-1:0] seg_q [NUM_SEGS]
);

  // Named arbitration events
  logic                pop_ok;
  logic                grant_far, grant_pop, grant_lfp;
  logic [NUM_SEGS-1:0] wr_en;
  logic [SEG_W-1:0]    wr_data;

  assign pop_ok    = pop_we && (seg_id_e'(pop_seg) != SEG_CODE);
  assign grant_far = far_we;
  assign grant_pop = pop_ok && !far_we;
  assign grant_lfp = lfp_we && !far_we && !pop_ok;

  always_comb begin
    wr_en   = '0;
    wr_data = far_cs;
    if (grant_far) begin
      wr_en[int'(SEG_CODE)] = 1'b1;
    end else if (grant_pop) begin
      wr_en[pop_seg] = 1'b1;
      wr_data        = pop_data;
    end else if (grant_lfp) begin
      wr_en[int'(SEG_DATA)] = 1'b1;
      wr_data               = lfp_ds;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SEGS; i++)
        seg_q[i] <= (i == int'(SEG_CODE)) ? CS_RST : '0;
    end else begin
      for (int i = 0; i < NUM_SEGS; i++)
        if (wr_en[i]) seg_q[i] <= wr_data;
    end
  end

  // R10: one register written per edge
  p_one_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));

  // R10: far transfer wins over every other request
  p_far_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    far_we |=> (seg_q[int'(SEG_CODE)] == $past(far_cs)));

  // R7: code base moves only on a far transfer
  p_cs_far_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !far_we |=> $stable(seg_q[int'(SEG_CODE)]));

  // R8: stack base moves only on a winning pop aimed at it
  p_ss_pop_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop_we && pop_seg == 2'b10 && !far_we) |=> $stable(seg_q[int'(SEG_STACK)]));

  // R9: data base keeps its value without a pop or far-pointer load
  p_ds_sources_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (far_we || (!(pop_we && pop_seg == 2'b11) && !lfp_we))
      |=> $stable(seg_q[int'(SEG_DATA)]));

endmodule

// File: rtl/seg_select.sv
module seg_select
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       base_kind,
  input  logic             ovr_valid,
  input  logic [1:0]       ovr_seg,
  input  logic [SEG_W-1:0] seg_q [NUM_SEGS],
  output logic [1:0]       sel_id,
  output logic [SEG_W-1:0] sel_base
);

  logic    is_fetch;
  seg_id_e dflt_id;

  assign is_fetch = (base_kind_e'(base_kind) == BASE_IP);
  assign dflt_id  = default_seg(base_kind_e'(base_kind));

  always_comb begin
    if (ovr_valid && !is_fetch) sel_id = ovr_seg;
    else                        sel_id = dflt_id;
  end

  assign sel_base = seg_q[sel_id];

  // R2: fetches never leave the code segment
  p_fetch_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (base_kind == 2'b00) |-> (sel_id == 2'b01));

  // R3: stack-pointer offsets use the stack segment by default
  p_stack_dflt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (base_kind == 2'b01 && !ovr_valid) |-> (sel_id == 2'b10));

  // R4: general and index offsets use the data segment by default
  p_data_dflt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (base_kind[1] && !ovr_valid) |-> (sel_id == 2'b11));

endmodule

// File: rtl/phys_adder.sv
module phys_adder #(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEG_W-1:0]  seg_base,
  input  logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] phys_addr
);

  localparam int SHIFT = ADDR_W - SEG_W;

  // Shift base, zero-extend offset, keep ADDR_W bits (wraps at the top).
  function automatic logic [ADDR_W-1:0] form_addr(
    input logic [SEG_W-1:0] base, input logic [OFF_W-1:0] off);
    logic [ADDR_W-1:0] shifted;
    shifted = {base, {SHIFT{1'b0}}};
    return shifted + ADDR_W'(off);
  endfunction

  assign phys_addr = form_addr(seg_base, offset);

  // R1: low nibble passes straight from the offset
  p_low_nibble_r1: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[SHIFT-1:0] == offset[SHIFT-1:0]);

endmodule

// File: rtl/seg_addr_unit.sv
module seg_addr_unit
  import seg_addr_pkg::*;
#(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int ADDR_W = 20,
  parameter logic [SEG_W-1:0] CS_RST = {SEG_W{1'b1}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        base_kind,
  input  logic [OFF_W-1:0]  offset,
  input  logic              ovr_valid,
  input  logic [1:0]        ovr_seg,
  input  logic              far_we,
  input  logic [SEG_W-1:0]  far_cs,
  input  logic              pop_we,
  input  logic [1:0]        pop_seg,
  input  logic [SEG_W-1:0]  pop_data,
  input  logic              lfp_we,
  input  logic [SEG_W-1:0]  lfp_ds,
  output logic [ADDR_W-1:0] phys_addr
);

  logic [SEG_W-1:0] seg_q [NUM_SEGS];
  logic [1:0]       sel_id;
  logic [SEG_W-1:0] sel_base;

  seg_regfile #(.SEG_W(SEG_W), .CS_RST(CS_RST)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .far_we(far_we), .far_cs(far_cs),
    .pop_we(pop_we), .pop_seg(pop_seg), .pop_data(pop_data),
    .lfp_we(lfp_we), .lfp_ds(lfp_ds),
    .seg_q(seg_q)
  );

  seg_select #(.SEG_W(SEG_W)) u_sel (
    .clk(clk), .rst_n(rst_n),
    .base_kind(base_kind), .ovr_valid(ovr_valid), .ovr_seg(ovr_seg),
    .seg_q(seg_q), .sel_id(sel_id), .sel_base(sel_base)
  );

  phys_adder #(.SEG_W(SEG_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) u_add (
    .clk(clk), .rst_n(rst_n),
    .seg_base(sel_base), .offset(offset), .phys_addr(phys_addr)
  );

  // R5: a valid override on a non-fetch picks the named segment
  p_override_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_valid && base_kind != 2'b00) |-> (sel_id == ovr_seg));

endmodule

// File: tb/seg_addr_unit_bench.sv
module seg_addr_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  base_kind;
  logic [15:0] offset;
  logic        ovr_valid;
  logic [1:0]  ovr_seg;
  logic        far_we;
  logic [15:0] far_cs;
  logic        pop_we;
  logic [1:0]  pop_seg;
  logic [15:0] pop_data;
  logic        lfp_we;
  logic [15:0] lfp_ds;
  logic [19:0] phys_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  seg_addr_unit u_seg_addr_unit (.*);

  typedef struct packed {
    logic [3:0]  req;
    logic [1:0]  kind;
    logic        ov;
    logic [1:0]  sel;
    logic [15:0] off;
    logic [19:0] exp;
  } vec_t;

  // Bases during the table: CS=1234 SS=2000 DS=3456 ES=FFFF
  localparam vec_t VECS [10] = '{
    '{4'd2,  2'b00, 1'b0, 2'b00, 16'h0010, 20'h12350},
    '{4'd2,  2'b00, 1'b1, 2'b11, 16'h0001, 20'h12341},
    '{4'd3,  2'b01, 1'b0, 2'b00, 16'h0100, 20'h20100},
    '{4'd4,  2'b10, 1'b0, 2'b00, 16'hABCD, 20'h3F12D},
    '{4'd4,  2'b11, 1'b0, 2'b00, 16'h0000, 20'h34560},
    '{4'd1,  2'b01, 1'b1, 2'b00, 16'h0020, 20'h00010},
    '{4'd5,  2'b10, 1'b1, 2'b10, 16'h0004, 20'h20004},
    '{4'd1,  2'b10, 1'b1, 2'b01, 16'hFFFF, 20'h2233F},
    '{4'd5,  2'b01, 1'b0, 2'b00, 16'h0005, 20'h20005},
    '{4'd5,  2'b11, 1'b1, 2'b11, 16'h1111, 20'h35671}
  };

  task automatic check(input string req, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%05h expected=%05h", req, act, exp);
    end
  endtask

  task automatic probe(input logic [1:0] k, input logic v, input logic [1:0] s,
                       input logic [15:0] o);
    base_kind = k; ovr_valid = v; ovr_seg = s; offset = o;
    #1;
  endtask

  task automatic wr(input logic f, input logic [15:0] fv,
                    input logic p, input logic [1:0] ps, input logic [15:0] pv,
                    input logic l, input logic [15:0] lv);
    @(negedge clk);
    far_we = f; far_cs = fv; pop_we = p; pop_seg = ps; pop_data = pv;
    lfp_we = l; lfp_ds = lv;
    @(negedge clk);
    far_we = 1'b0; pop_we = 1'b0; lfp_we = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    base_kind = 2'b00; offset = '0; ovr_valid = 1'b0; ovr_seg = 2'b00;
    far_we = 1'b0; far_cs = '0; pop_we = 1'b0; pop_seg = '0; pop_data = '0;
    lfp_we = 1'b0; lfp_ds = '0;
    repeat (3) @(negedge clk);
    probe(2'b00, 1'b0, 2'b00, 16'h0000); check("R6 code during reset", phys_addr, 20'hFFFF0);
    rst_n = 1'b1;
    @(negedge clk);
    probe(2'b00, 1'b0, 2'b00, 16'h0000); check("R6 code base", phys_addr, 20'hFFFF0);
    probe(2'b01, 1'b0, 2'b00, 16'h0000); check("R6 stack base", phys_addr, 20'h00000);
    probe(2'b10, 1'b0, 2'b00, 16'h0000); check("R6 data base", phys_addr, 20'h00000);
    probe(2'b10, 1'b1, 2'b00, 16'h0000); check("R6 extra base", phys_addr, 20'h00000);

    // Load the bases used by the table
    wr(1'b1, 16'h1234, 1'b0, 2'b00, 16'h0, 1'b0, 16'h0);
    probe(2'b00, 1'b0, 2'b00, 16'h0000); check("R7 far write", phys_addr, 20'h12340);
    wr(1'b0, 16'h0, 1'b1, 2'b10, 16'h2000, 1'b0, 16'h0);
    probe(2'b01, 1'b0, 2'b00, 16'h0000); check("R8 pop stack", phys_addr, 20'h20000);
    wr(1'b0, 16'h0, 1'b0, 2'b00, 16'h0, 1'b1, 16'h3456);
    probe(2'b11, 1'b0, 2'b00, 16'h0000); check("R9 lfp data", phys_addr, 20'h34560);
    wr(1'b0, 16'h0, 1'b1, 2'b00, 16'hFFFF, 1'b0, 16'h0);
    probe(2'b01, 1'b1, 2'b00, 16'h0000); check("R8 pop extra", phys_addr, 20'hFFFF0);

    for (int i = 0; i < 10; i++) begin
      probe(VECS[i].kind, VECS[i].ov, VECS[i].sel, VECS[i].off);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), phys_addr, VECS[i].exp);
    end

    // R10: all three at once, far wins, pop and lfp dropped
    wr(1'b1, 16'h0AAA, 1'b1, 2'b10, 16'h5555, 1'b1, 16'h6666);
    probe(2'b00, 1'b0, 2'b00, 16'h0000); check("R10 far wins code", phys_addr, 20'h0AAA0);
    probe(2'b01, 1'b0, 2'b00, 16'h0000); check("R10 pop dropped stack", phys_addr, 20'h20000);
    probe(2'b10, 1'b0, 2'b00, 16'h0000); check("R10 lfp dropped data", phys_addr, 20'h34560);
    // R10: pop beats lfp on the data base
    wr(1'b0, 16'h0, 1'b1, 2'b11, 16'h7777, 1'b1, 16'h8888);
    probe(2'b10, 1'b0, 2'b00, 16'h0000); check("R10 pop beats lfp", phys_addr, 20'h77770);
    // R8: pop aimed at code is discarded
    wr(1'b0, 16'h0, 1'b1, 2'b01, 16'h9999, 1'b0, 16'h0);
    probe(2'b00, 1'b0, 2'b00, 16'h0000); check("R8 pop code ignored", phys_addr, 20'h0AAA0);
    // R8/R10: discarded pop does not block lfp
    wr(1'b0, 16'h0, 1'b1, 2'b01, 16'h9999, 1'b1, 16'h4444);
    probe(2'b00, 1'b0, 2'b00, 16'h0000); check("R8 code kept", phys_addr, 20'h0AAA0);
    probe(2'b11, 1'b0, 2'b00, 16'h0000); check("R9 lfp after bad pop", phys_addr, 20'h44440);
    // R7: lfp and pop never reach the code base
    probe(2'b00, 1'b1, 2'b10, 16'hFFFF); check("R7 code with override on fetch", phys_addr, 20'h1AA9F);
    // R1: wrap through the code base
    wr(1'b1, 16'hFFFF, 1'b0, 2'b00, 16'h0, 1'b0, 16'h0);
    probe(2'b00, 1'b0, 2'b00, 16'hFFFF); check("R1 wrap at top", phys_addr, 20'h0FFEF);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule